// File: doc/BRIEF.md
# External Memory Bus Sequencer

This block connects a simple internal request port to an asynchronous external memory bus. A request carries a 32-bit byte address, a 16-bit write word and a read/write flag. The block compares the address against six fixed windows and picks one of six active-low chip selects. It then plays out a timed sequence on the external pins: chip select, a 9-bit halfword address, an address-valid strobe, an output-enable strobe for reads, and a write-enable strobe for writes. The 16-bit data path is split at the pad into an output word, an output enable and an input word. When the access is done, a one-cycle response returns. For a read, the response carries the captured data word.

Each chip select has its own timing word, written through a small configuration port. The word sets the wait-strobe length, write hold, read setup, the spacing from address-valid to output enable, an optional address-hold cycle, and a recovery gap. Recovery is inserted only after a read, and only when the next access goes to another chip select or is a write. The word also sets an extra first-access latency, separate for reads and writes. That latency applies whenever the access leaves the current page. A page means the same chip select and the same address bits 31..10.

A request that falls outside every window gets an error response and touches no pin. The internal port accepts a request only while the sequencer is idle.

Top module: `xbus_ctrl`

## Requirements
- R1: Windows map to chip selects as follows, with the end bound exclusive: index 0 is 0x1A800000..0x1B000000, index 1 is 0x1B000000..0x1B800000, index 2 is 0x1B800000..0x1C000000, index 5 is 0x1C000000..0x1C800000, index 4 is 0x1C800000..0x1D000000, and index 3 is 0x1D000000..0x25000000. A hit drives `xb_cs_n[index]` low, and no other chip select goes low. While the chip select is active, `xb_addr` carries address bits 9..1; otherwise it is 0.
- R2: A request that hits no window gives `rsp_valid`=1 and `rsp_err`=1 in the cycle after it is accepted, with no chip select, strobe or data drive.
- R3: The strobe phase lasts wait+1 cycles, where wait is a 4-bit field. It uses `xb_oe_n` low for reads with the read-wait field, and `xb_we_n` low for writes with the write-wait field. The chip select is active throughout.
- R4: Recovery is a gap with all pins idle, placed right after acceptance. It lasts max(1, recovery field of the previous chip select) cycles. It is inserted only when the previous access was a read and the new access either targets a different chip select or is a write.
- R5: After the write strobe, the chip select and the data drive (`xb_data_oe`=1, `xb_data_o` = write word) stay active for hold+1 cycles. `xb_data_oe` is 1 only in the write strobe and write hold phases.
- R6: When an access changes chip select or address bits 31..10 relative to the previous decoded access, it gets read-delta or write-delta extra cycles (8-bit fields) first, with the chip select active. Every access after reset counts as a first access.
- R7: Every access has exactly one cycle with `xb_adv_n` low. When the address-hold bit is set, one further cycle follows with the chip select active and the address driven.
- R8: A read spends read-hold cycles (4-bit field) with only the chip select active before the address-valid cycle. It then spends adv-to-OE cycles (2-bit field) between the address-valid or address-hold cycle and the first output-enable cycle.
- R9: Read data is sampled from `xb_data_i` in the last output-enable cycle. `rsp_valid` pulses for one cycle right after the final phase cycle, and `req_ready` is 1 in that cycle.
- R10: A configuration write with `cfg_we`=1 loads `cfg_wdata` into the timing word of chip select `cfg_idx`. The bit fields are: [38:31] write delta, [30:23] read delta, [22:19] read hold, [18:15] write hold, [14:11] recovery, [10:7] write wait, [6:3] read wait, [2:1] adv-to-OE, [0] address hold. An index of 6 or 7 changes nothing.
- R11: After reset, every timing word is zero. All chip selects and strobes are high, the data drive is off, `req_ready`=1 and `rsp_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Timing word write strobe |
| cfg_idx | input | 3 | Chip select whose timing word is written |
| cfg_wdata | input | 39 | Timing word |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 16 | Write word |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Request hit no window |
| rsp_rdata | output | 16 | Captured read word |
| xb_cs_n | output | 6 | Active-low chip selects |
| xb_addr | output | 9 | External halfword address |
| xb_adv_n | output | 1 | Active-low address valid |
| xb_oe_n | output | 1 | Active-low output enable |
| xb_we_n | output | 1 | Active-low write enable |
| xb_data_o | output | 16 | Data to the pad |
| xb_data_oe | output | 1 | Pad output enable |
| xb_data_i | input | 16 | Data from the pad |

## Verification
The external pins change in the cycle after the accepting clock edge, and each phase then holds for exactly its programmed cycle count. The response follows one cycle after the final phase cycle, or one cycle after acceptance for a miss. The bench therefore expands each request into a queue with one expected pin vector per cycle, which it builds from the timing words it wrote, its own window table and its own page and recovery history. It pops one entry at every falling edge, so each output is compared in the very cycle it is due. The external device model changes its read word on every output-enable cycle, which shows exactly which cycle the read capture used.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
    localparam int NCS  = 6;
    localparam int CSW  = 3;
    localparam int AW   = 32;
    localparam int DW   = 16;
    localparam int XAW  = 9;
    localparam int TAGW = AW - XAW - 1;
    localparam int CFGW = 39;
    localparam int NPH  = 8;
    localparam int LENW = 9;

    typedef struct packed {
        logic [7:0] wr_delta;
        logic [7:0] rd_delta;
        logic [3:0] rd_hold;
        logic [3:0] wr_hold;
        logic [3:0] recov;
        logic [3:0] wr_wait;
        logic [3:0] rd_wait;
        logic [1:0] adv_oe;
        logic       ahold_en;
    } tcfg_t;

    // Phase order is the order of the external sequence.
    typedef enum logic [3:0] {
        PH_IDLE   = 4'd0,
        PH_RECOV  = 4'd1,
        PH_DELTA  = 4'd2,
        PH_SETUP  = 4'd3,
        PH_ADV    = 4'd4,
        PH_AHOLD  = 4'd5,
        PH_GAP    = 4'd6,
        PH_STROBE = 4'd7,
        PH_WHOLD  = 4'd8
    } phase_e;

    localparam logic [AW-1:0] WIN_BASE [NCS] = '{
        32'h1A80_0000, 32'h1B00_0000, 32'h1B80_0000,
        32'h1D00_0000, 32'h1C80_0000, 32'h1C00_0000};
    localparam logic [AW-1:0] WIN_END [NCS] = '{
        32'h1B00_0000, 32'h1B80_0000, 32'h1C00_0000,
        32'h2500_0000, 32'h1D00_0000, 32'h1C80_0000};

    function automatic logic [LENW-1:0] phase_len(phase_e ph, tcfg_t c, logic wr,
                                                   logic need_rec, logic first,
                                                   logic [3:0] rec_prev);
        case (ph)
            PH_RECOV:  return need_rec ? ((rec_prev == 4'd0) ? LENW'(1) : LENW'(rec_prev)) : '0;
            PH_DELTA:  return first ? LENW'(wr ? c.wr_delta : c.rd_delta) : '0;
            PH_SETUP:  return wr ? '0 : LENW'(c.rd_hold);
            PH_ADV:    return LENW'(1);
            PH_AHOLD:  return c.ahold_en ? LENW'(1) : '0;
            PH_GAP:    return wr ? '0 : LENW'(c.adv_oe);
            PH_STROBE: return LENW'(wr ? c.wr_wait : c.rd_wait) + LENW'(1);
            PH_WHOLD:  return wr ? LENW'(c.wr_hold) + LENW'(1) : '0;
            default:   return '0;
        endcase
    endfunction
endpackage

// File: rtl/xbus_decode.sv
module xbus_decode
    import xbus_pkg::*;
#(
    parameter int N_CS = NCS,
    parameter int A_W  = AW,
    parameter int C_W  = CSW
) (
    input  logic [A_W-1:0] addr,
    output logic           hit,
    output logic [C_W-1:0] cs
);
    logic [N_CS-1:0] in_win;

    for (genvar i = 0; i < N_CS; i++) begin : g_win
        assign in_win[i] = (addr >= WIN_BASE[i]) && (addr < WIN_END[i]);
    end

    always_comb begin
        hit = |in_win;
        cs  = '0;
        for (int i = 0; i < N_CS; i++) begin
            if (in_win[i]) cs = C_W'(i);
        end
    end
endmodule

// File: rtl/xbus_cfg.sv
module xbus_cfg
    import xbus_pkg::*;
#(
    parameter int N_CS = NCS,
    parameter int C_W  = CSW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [C_W-1:0]       cfg_idx,
    input  logic [CFGW-1:0]      cfg_wdata,
    output tcfg_t [N_CS-1:0]     cfg_all
);
    tcfg_t [N_CS-1:0] cfg_d, cfg_q;

    for (genvar i = 0; i < N_CS; i++) begin : g_slot
        always_comb begin
            cfg_d[i] = cfg_q[i];
            if (cfg_we && cfg_idx == C_W'(i)) cfg_d[i] = tcfg_t'(cfg_wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg_all = cfg_q;

    AST_CFG_OOR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_idx >= C_W'(N_CS)) |=> $stable(cfg_q)); // R10
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int N_CS = NCS,
    parameter int C_W  = CSW,
    parameter int A_W  = AW,
    parameter int D_W  = DW,
    parameter int XA_W = XAW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [A_W-1:1]     req_addr,
    input  logic [D_W-1:0]     req_wdata,
    input  logic               hit,
    input  logic [C_W-1:0]     hit_cs,
    input  tcfg_t [N_CS-1:0]   cfg_all,
    output logic               rsp_valid,
    output logic               rsp_err,
    output logic [D_W-1:0]     rsp_rdata,
    output logic [N_CS-1:0]    xb_cs_n,
    output logic [XA_W-1:0]    xb_addr,
    output logic               xb_adv_n,
    output logic               xb_oe_n,
    output logic               xb_we_n,
    output logic [D_W-1:0]     xb_data_o,
    output logic               xb_data_oe,
    input  logic [D_W-1:0]     xb_data_i
);
    localparam int TAG_W = A_W - XA_W - 1;

    typedef struct packed {
        phase_e            ph;
        logic [LENW-1:0]   cnt;
        logic              wr;
        logic [C_W-1:0]    cs;
        logic [XA_W-1:0]   xaddr;
        logic [D_W-1:0]    wdata;
        logic              need_rec;
        logic              first;
        logic [3:0]        rec_prev;
        logic              last_rd;
        logic [C_W-1:0]    last_cs;
        logic              pg_vld;
        logic [C_W-1:0]    pg_cs;
        logic [TAG_W-1:0]  pg_tag;
        logic              rsp_vld;
        logic              rsp_err;
        logic [D_W-1:0]    rdata;
    } st_t;

    st_t st_d, st_q;
    logic [TAG_W-1:0] req_tag;
    logic             go;
    logic [3:0]       from;
    logic             found;
    phase_e           nph;
    logic [LENW-1:0]  nlen, plen;
    logic [3:0]       pv;
    logic             active;

    assign req_tag = req_addr[A_W-1:XA_W+1];

    always_comb begin
        st_d         = st_q;
        st_d.rsp_vld = 1'b0;
        st_d.rsp_err = 1'b0;
        go           = 1'b0;
        from         = 4'd1;
        if (st_q.ph == PH_IDLE) begin
            if (req_valid) begin
                if (!hit) begin
                    st_d.rsp_vld = 1'b1;
                    st_d.rsp_err = 1'b1;
                end else begin
                    st_d.wr       = req_write;
                    st_d.cs       = hit_cs;
                    st_d.xaddr    = req_addr[XA_W:1];
                    st_d.wdata    = req_wdata;
                    st_d.need_rec = st_q.last_rd && (hit_cs != st_q.last_cs || req_write);
                    st_d.first    = !(st_q.pg_vld && st_q.pg_cs == hit_cs && st_q.pg_tag == req_tag);
                    st_d.rec_prev = cfg_all[st_q.last_cs].recov;
                    st_d.last_rd  = !req_write;
                    st_d.last_cs  = hit_cs;
                    st_d.pg_vld   = 1'b1;
                    st_d.pg_cs    = hit_cs;
                    st_d.pg_tag   = req_tag;
                    go            = 1'b1;
                end
            end
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - LENW'(1);
        end else begin
            if (st_q.ph == PH_STROBE && !st_q.wr) st_d.rdata = xb_data_i;
            go   = 1'b1;
            from = 4'(st_q.ph) + 4'd1;
        end

        // Next non-empty phase at or after 'from'.
        found = 1'b0;
        nph   = PH_IDLE;
        nlen  = '0;
        for (int p = 1; p <= NPH; p++) begin
            pv   = 4'(p);
            plen = phase_len(phase_e'(pv), cfg_all[st_d.cs], st_d.wr,
                             st_d.need_rec, st_d.first, st_d.rec_prev);
            if (!found && pv >= from && plen != '0) begin
                found = 1'b1;
                nph   = phase_e'(pv);
                nlen  = plen;
            end
        end
        if (go) begin
            st_d.ph  = nph;
            st_d.cnt = found ? nlen - LENW'(1) : '0;
            if (!found) st_d.rsp_vld = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Pin decode from the registered phase.
    assign active = (st_q.ph != PH_IDLE) && (st_q.ph != PH_RECOV);

    always_comb begin
        for (int i = 0; i < N_CS; i++) begin
            xb_cs_n[i] = !(active && st_q.cs == C_W'(i));
        end
    end

    assign xb_addr    = active ? st_q.xaddr : '0;
    assign xb_adv_n   = (st_q.ph != PH_ADV);
    assign xb_oe_n    = !(st_q.ph == PH_STROBE && !st_q.wr);
    assign xb_we_n    = !(st_q.ph == PH_STROBE && st_q.wr);
    assign xb_data_oe = st_q.wr && (st_q.ph == PH_STROBE || st_q.ph == PH_WHOLD);
    assign xb_data_o  = st_q.wdata;
    assign req_ready  = (st_q.ph == PH_IDLE);
    assign rsp_valid  = st_q.rsp_vld;
    assign rsp_err    = st_q.rsp_err;
    assign rsp_rdata  = st_q.rdata;

    AST_ONE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~xb_cs_n)); // R1
    AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !hit) |=> (rsp_valid && rsp_err && xb_cs_n == '1 && !xb_data_oe)); // R2
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!xb_oe_n && !xb_we_n)); // R3
    AST_OE_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (!xb_oe_n || !xb_we_n) |-> (xb_cs_n != '1)); // R3
    AST_RECOV_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_RECOV) |-> (xb_cs_n == '1 && xb_oe_n && xb_we_n)); // R4
    AST_DRIVE_NOT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        xb_data_oe |-> xb_oe_n); // R5
    AST_WE_THEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xb_we_n) |-> (xb_cs_n != '1 && xb_data_oe)); // R5
    AST_ADV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        !xb_adv_n |=> xb_adv_n); // R7
    AST_RSP_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> req_ready); // R9
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
    import xbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CSW-1:0]    cfg_idx,
    input  logic [CFGW-1:0]   cfg_wdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [AW-1:0]     req_addr,
    input  logic [DW-1:0]     req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DW-1:0]     rsp_rdata,
    output logic [NCS-1:0]    xb_cs_n,
    output logic [XAW-1:0]    xb_addr,
    output logic              xb_adv_n,
    output logic              xb_oe_n,
    output logic              xb_we_n,
    output logic [DW-1:0]     xb_data_o,
    output logic              xb_data_oe,
    input  logic [DW-1:0]     xb_data_i
);
    logic             hit;
    logic [CSW-1:0]   hit_cs;
    tcfg_t [NCS-1:0]  cfg_all;

    xbus_decode u_decode (
        .addr (req_addr),
        .hit  (hit),
        .cs   (hit_cs)
    );

    xbus_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .cfg_all   (cfg_all)
    );

    xbus_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_addr   (req_addr[AW-1:1]),
        .req_wdata  (req_wdata),
        .hit        (hit),
        .hit_cs     (hit_cs),
        .cfg_all    (cfg_all),
        .rsp_valid  (rsp_valid),
        .rsp_err    (rsp_err),
        .rsp_rdata  (rsp_rdata),
        .xb_cs_n    (xb_cs_n),
        .xb_addr    (xb_addr),
        .xb_adv_n   (xb_adv_n),
        .xb_oe_n    (xb_oe_n),
        .xb_we_n    (xb_we_n),
        .xb_data_o  (xb_data_o),
        .xb_data_oe (xb_data_oe),
        .xb_data_i  (xb_data_i)
    );
endmodule

// File: tb/tb_xbus_ctrl.sv
module tb_xbus_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [38:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        rsp_valid, rsp_err;
    logic [15:0] rsp_rdata;
    logic [5:0]  xb_cs_n;
    logic [8:0]  xb_addr;
    logic        xb_adv_n, xb_oe_n, xb_we_n, xb_data_oe;
    logic [15:0] xb_data_o, xb_data_i;
    logic [15:0] oecnt;

    always #5 clk = ~clk;

    xbus_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .xb_cs_n(xb_cs_n), .xb_addr(xb_addr),
        .xb_adv_n(xb_adv_n), .xb_oe_n(xb_oe_n), .xb_we_n(xb_we_n),
        .xb_data_o(xb_data_o), .xb_data_oe(xb_data_oe), .xb_data_i(xb_data_i)
    );

    // External device: the read word steps by one on every output-enable cycle.
    always @(posedge clk) begin
        if (!rst_n) oecnt <= '0;
        else        oecnt <= xb_oe_n ? 16'd0 : oecnt + 16'd1;
    end
    assign xb_data_i = xb_oe_n ? 16'hFFFF : (({7'd0, xb_addr} ^ 16'h5A00) + oecnt);

    typedef struct {
        logic [39:0] v;
        logic        chk_rd;
        logic [15:0] rd;
        int          rq;
    } exp_t;

    exp_t eq[$];
    int checks = 0;
    int fails = 0;
    bit done = 0;

    int m_rw[6], m_ww[6], m_rc[6], m_wh[6], m_rd[6], m_wd[6], m_ao[6], m_ah[6], m_rh[6];
    int m_last_rd = 0, m_last_cs = 0, m_pv = 0, m_pcs = 0;
    logic [21:0] m_ptag = '0;

    function automatic logic [39:0] mk(int cs, bit adv, bit oe, bit we, bit doe,
                                       bit rsp, bit err, bit rdy, logic [8:0] a, logic [15:0] dat);
        logic [5:0] c;
        c = 6'h3F;
        if (cs >= 0) c[cs] = 1'b0;
        return {c, ~adv, ~oe, ~we, doe, rsp, err, rdy, (cs >= 0) ? a : 9'd0, doe ? dat : 16'd0};
    endfunction

    function automatic int win(logic [31:0] a);
        if (a >= 32'h1A80_0000 && a < 32'h1B00_0000) return 0;
        if (a >= 32'h1B00_0000 && a < 32'h1B80_0000) return 1;
        if (a >= 32'h1B80_0000 && a < 32'h1C00_0000) return 2;
        if (a >= 32'h1C00_0000 && a < 32'h1C80_0000) return 5;
        if (a >= 32'h1C80_0000 && a < 32'h1D00_0000) return 4;
        if (a >= 32'h1D00_0000 && a < 32'h2500_0000) return 3;
        return -1;
    endfunction

    task automatic push(logic [39:0] v, int rq, int n);
        exp_t e;
        e.v = v; e.chk_rd = 1'b0; e.rd = '0; e.rq = rq;
        for (int i = 0; i < n; i++) eq.push_back(e);
    endtask

    task automatic tick();
        exp_t e;
        logic [39:0] obs;
        @(negedge clk);
        if (eq.size() > 0) e = eq.pop_front();
        else begin
            e.v = mk(-1, 0, 0, 0, 0, 0, 0, 1, 9'd0, 16'd0); e.chk_rd = 1'b0; e.rd = '0; e.rq = 11; // R11 quiet bus
        end
        obs = {xb_cs_n, xb_adv_n, xb_oe_n, xb_we_n, xb_data_oe, rsp_valid, rsp_err, req_ready,
               xb_addr, xb_data_oe ? xb_data_o : 16'd0};
        checks++;
        if (obs !== e.v) begin
            fails++;
            $display("FAIL R%0d pins actual=%h expected=%h at %0t", e.rq, obs, e.v, $time);
        end
        if (e.chk_rd) begin
            checks++;
            if (rsp_rdata !== e.rd) begin
                fails++;
                $display("FAIL R9 read data actual=%h expected=%h", rsp_rdata, e.rd);
            end
        end
    endtask

    task automatic set_cfg(int idx, int rw, int ww, int rc, int wh, int rd, int wd,
                           int ao, int ah, int rh);
        tick();
        cfg_we = 1'b1;
        cfg_idx = 3'(idx);
        // R10 field layout
        cfg_wdata = {8'(wd), 8'(rd), 4'(rh), 4'(wh), 4'(rc), 4'(ww), 4'(rw), 2'(ao), 1'(ah)};
        if (idx < 6) begin
            m_rw[idx] = rw; m_ww[idx] = ww; m_rc[idx] = rc; m_wh[idx] = wh; m_rd[idx] = rd;
            m_wd[idx] = wd; m_ao[idx] = ao; m_ah[idx] = ah; m_rh[idx] = rh;
        end
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic access(bit w, logic [31:0] a, logic [15:0] dat, int rq);
        int cs;
        int rec;
        bit first;
        logic [8:0] xa;
        exp_t e;
        cs = win(a);
        xa = a[9:1];
        tick();
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = dat;
        if (cs < 0) begin
            push(mk(-1, 0, 0, 0, 0, 1, 1, 1, 9'd0, 16'd0), 2, 1); // R2
        end else begin
            rec = 0;
            if (m_last_rd != 0 && (cs != m_last_cs || w))
                rec = (m_rc[m_last_cs] == 0) ? 1 : m_rc[m_last_cs];
            push(mk(-1, 0, 0, 0, 0, 0, 0, 0, xa, dat), 4, rec);                      // R4
            first = !(m_pv != 0 && m_pcs == cs && m_ptag == a[31:10]);
            if (first) push(mk(cs, 0, 0, 0, 0, 0, 0, 0, xa, dat), 6, w ? m_wd[cs] : m_rd[cs]); // R6
            if (!w) push(mk(cs, 0, 0, 0, 0, 0, 0, 0, xa, dat), 8, m_rh[cs]);          // R8
            push(mk(cs, 1, 0, 0, 0, 0, 0, 0, xa, dat), 7, 1);                         // R7
            if (m_ah[cs] != 0) push(mk(cs, 0, 0, 0, 0, 0, 0, 0, xa, dat), 7, 1);
            if (!w) push(mk(cs, 0, 0, 0, 0, 0, 0, 0, xa, dat), 8, m_ao[cs]);
            if (w) begin
                push(mk(cs, 0, 0, 1, 1, 0, 0, 0, xa, dat), 3, m_ww[cs] + 1);          // R3
                push(mk(cs, 0, 0, 0, 1, 0, 0, 0, xa, dat), 5, m_wh[cs] + 1);          // R5
            end else begin
                push(mk(cs, 0, 1, 0, 0, 0, 0, 0, xa, dat), 3, m_rw[cs] + 1);          // R3
            end
            e.v = mk(-1, 0, 0, 0, 0, 1, 0, 1, 9'd0, 16'd0);
            e.chk_rd = !w;
            e.rd = ({7'd0, xa} ^ 16'h5A00) + 16'(m_rw[cs]);
            e.rq = rq;
            eq.push_back(e);
            m_last_rd = w ? 0 : 1; m_last_cs = cs;
            m_pv = 1; m_pcs = cs; m_ptag = a[31:10];
        end
        tick();
        req_valid = 1'b0;
        while (eq.size() > 0) tick();
    endtask

    initial begin
        for (int i = 0; i < 6; i++) begin
            m_rw[i] = 0; m_ww[i] = 0; m_rc[i] = 0; m_wh[i] = 0; m_rd[i] = 0;
            m_wd[i] = 0; m_ao[i] = 0; m_ah[i] = 0; m_rh[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) tick();                                   // R11 reset state
        access(1'b0, 32'h1A80_0004, 16'h0, 11);              // R11 zero timing words
        set_cfg(2, 2, 1, 0, 2, 3, 4, 1, 1, 2);
        set_cfg(3, 1, 0, 3, 0, 0, 0, 0, 0, 0);
        access(1'b0, 32'h1B80_0010, 16'h0, 6);               // R6 first read of page
        access(1'b0, 32'h1B80_0020, 16'h0, 6);               // R6 same page, no delta
        access(1'b1, 32'h1B80_0030, 16'hBEEF, 4);            // R4 read then write, same cs
        access(1'b1, 32'h1B80_0032, 16'h1234, 5);            // R5 write after write
        access(1'b0, 32'h1D00_0100, 16'h0, 3);               // R3 read on cs index 3
        access(1'b0, 32'h1B80_0040, 16'h0, 4);               // R4 read after read, other cs
        access(1'b1, 32'h1B80_0830, 16'hC0DE, 6);            // R6 write to new page
        access(1'b0, 32'h1B80_0440, 16'h0, 9);               // R9 read capture
        access(1'b0, 32'h1A80_0000, 16'h0, 1);               // R1 window bounds
        access(1'b0, 32'h1B00_0000, 16'h0, 1);
        access(1'b0, 32'h1BFF_FFFE, 16'h0, 1);
        access(1'b0, 32'h1C00_0000, 16'h0, 1);
        access(1'b0, 32'h1C7F_FFFE, 16'h0, 1);
        access(1'b0, 32'h1C80_0000, 16'h0, 1);
        access(1'b0, 32'h24FF_FFFE, 16'h0, 1);
        access(1'b0, 32'h0000_1000, 16'h0, 2);               // R2 misses
        access(1'b1, 32'h2500_0000, 16'h5555, 2);
        access(1'b0, 32'h1A7F_FFFE, 16'h0, 2);
        set_cfg(7, 15, 15, 15, 15, 255, 255, 3, 1, 15);     // R10 out-of-range index
        access(1'b0, 32'h1B00_0100, 16'h0, 10);
        access(1'b1, 32'h1B00_0102, 16'h7777, 10);
        set_cfg(2, 3, 2, 2, 0, 0, 0, 3, 0, 0);               // R8 widest adv-to-OE, no setup
        access(1'b0, 32'h1B80_0444, 16'h0, 8);
        access(1'b1, 32'h1B80_0446, 16'hA5A5, 8);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R9 watchdog actual=hung expected=complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule